// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Mode and Programmable Threshold Flags

This block buffers 36-bit words between two clock domains. A producer writes on its own clock when the write enable is high. A consumer reads on a separate clock when the read enable is high. The two clocks may be unrelated or the same. Each side keeps its own binary pointer and publishes a Gray-coded copy. The opposite side brings that copy across through a two-stage synchroniser. Every status flag is therefore computed only from registers local to the clock that owns it.

A mode input is captured while the master reset is asserted, and it picks one of two read behaviours.

- **Standard mode:** every stored word needs an explicit read before it appears on the output.
- **Fall-through mode:** a holding register at the output pre-fetches the oldest word. The read-side flag then means "data valid".

The almost-empty and almost-full thresholds can come from three sources:

- a fixed preset chosen at master reset;
- two consecutive writes on the data bus (parallel load);
- a bit stream on a one-wire serial input (serial load).

A partial reset flushes the contents and returns both pointers to zero. It keeps the mode, the load method and the threshold values.

Top module: `dual_clk_fifo`

## Requirements
- R1: A write is accepted on a write-clock rising edge only when `wen` is high and the FIFO is not full. A write attempted while full is dropped: no later read returns it, and the word order of accepted data is preserved.
- R2: In standard mode (`fwft_sel`=0 at master reset), an accepted read loads the oldest word onto `rdata` at the same read-clock edge. A read while empty leaves `rdata` unchanged.
- R3: In fall-through mode (`fwft_sel`=1), the oldest word is moved to `rdata` without any read request. It is held there, with `rd_flag` high, until a read with `ren` high consumes it. `ren` while `rd_flag` is low has no effect.
- R4: `wr_flag` is the full indication (1 = full) in standard mode. It is the input-ready indication (1 = space available) in fall-through mode. Full means the memory of 2^ADDR_W words is occupied, as seen through the synchronised read pointer.
- R5: `rd_flag` is the empty indication (1 = empty) in standard mode. It is output-ready (1 = `rdata` valid) in fall-through mode.
- R6: `almost_full` is 1 when free memory words ≤ the almost-full offset, and it is timed by the write clock. `almost_empty` is 1 when unread words ≤ the almost-empty offset, and it is timed by the read clock. In fall-through mode the unread words include the word held on `rdata`.
- R7: `ofs_sel` captured at master reset sets both offsets to 8 (code 00), 16 (code 01) or 64 (code 10). Code 11 selects programmed offsets, which start at 0.
- R8: With code 11 and `ser_mode`=0, the first two writes accepted after reset are not stored. Their `wdata[6:0]` sets first the almost-empty offset and then the almost-full offset.
- R9: With code 11 and `ser_mode`=1, each write-clock edge with `ser_en` high shifts in `ser_din`. The stream carries the almost-empty offset first, then the almost-full offset, most significant bit first, 14 bits in total. Any further bits are ignored.
- R10: A partial reset (`prst_n` low) empties the FIFO and zeroes both pointers. The mode, the load method, the load progress and the offsets all survive it.
- R11: A word written at write edge k clears the empty indication after the read edge two cycles later (edge k+2, with shared clocks). A read at read edge k frees space on the write side after edge k+2.
- R12: The mode, `ofs_sel` and `ser_mode` are captured while the master reset is in force. After reset the FIFO is empty, `rdata` is zero, and the flags show empty and not full in the chosen mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, asynchronous assert |
| prst_n | input | 1 | Partial reset (flush), active low, asynchronous assert |
| fwft_sel | input | 1 | Mode captured at master reset: 0 standard, 1 fall-through |
| ofs_sel | input | 2 | Threshold source captured at master reset |
| ser_mode | input | 1 | Programmed offsets: 0 parallel, 1 serial |
| wen | input | 1 | Write enable |
| wdata | input | 36 | Write data; low 7 bits also carry parallel offsets |
| ser_en | input | 1 | Serial offset shift enable |
| ser_din | input | 1 | Serial offset bit |
| ren | input | 1 | Read enable |
| rdata | output | 36 | Read data |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| almost_empty | output | 1 | Unread words at or below the almost-empty offset |

## Verification
The assertions take for granted that the configuration inputs are stable for the whole master-reset pulse. They also assume that these inputs stay stable for two write clocks after it is released. Offsets are treated as quasi-static on the read side, so they must not change while data is flowing. The bench follows these rules: it changes configuration only inside a reset pulse, and it finishes every offset load before traffic starts. It drives both clocks from one source, which makes the two-edge synchroniser latency exact. That lets a cycle-level model predict every flag on every cycle.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

  typedef enum logic [1:0] {
    OFS_P8   = 2'b00,
    OFS_P16  = 2'b01,
    OFS_P64  = 2'b10,
    OFS_PROG = 2'b11
  } ofs_sel_e;

  function automatic logic [6:0] preset_ofs(ofs_sel_e s);
    case (s)
      OFS_P8:  return 7'd8;
      OFS_P16: return 7'd16;
      OFS_P64: return 7'd64;
      default: return 7'd0;
    endcase
  endfunction

endpackage

// File: rtl/fifo_rst_sync.sv
module fifo_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic stage1;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1 <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      stage1 <= 1'b1;
      srst_n <= stage1;
    end
  end
endmodule

// File: rtl/fifo_ptr_xing.sv
module fifo_ptr_xing #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  always_comb begin
    logic acc;
    acc = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      acc        = acc ^ sync_q[i];
      bin_out[i] = acc;
    end
  end
endmodule

// File: rtl/fifo_dpram.sv
module fifo_dpram #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 36
) (
  input  logic              wclk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/fifo_wr_side.sv
module fifo_wr_side
  import fifo_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              wclk,
  input  logic              wrst_n,
  input  logic              wmrst_n,
  input  logic              wen,
  input  logic [ADDR_W-1:0] wdata_lo,
  input  ofs_sel_e          ofs_sel_i,
  input  logic              ser_mode_i,
  input  logic              fwft_i,
  input  logic              ser_en,
  input  logic              ser_din,
  input  logic [ADDR_W:0]   rbin_sync,
  output logic              mem_we,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W:0]   wgray,
  output logic              fwft,
  output logic [ADDR_W-1:0] ae_ofs,
  output logic [ADDR_W-1:0] af_ofs,
  output logic              wr_flag,
  output logic              afull
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int SR_W  = 2 * ADDR_W;
  localparam int CNT_W = $clog2(SR_W + 1);
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  ofs_sel_e          sel_q;
  logic              ser_q;
  logic [SR_W-1:0]   ofs_q, ofs_d;
  logic [CNT_W-1:0]  ld_q, ld_d;
  logic [PTR_W-1:0]  wbin, wbin_d, wgray_d, wcount, free;
  logic              prog, loading, par_ld, ser_sh, full;

  // next-state logic
  always_comb begin
    prog    = (sel_q == OFS_PROG);
    loading = prog && !ser_q && (ld_q < CNT_W'(2));
    par_ld  = loading && wen && wrst_n;
    ser_sh  = prog && ser_q && (ld_q < CNT_W'(SR_W)) && ser_en && wrst_n;
    ofs_d   = ofs_q;
    ld_d    = ld_q;
    if (par_ld) begin
      if (ld_q == '0) ofs_d[SR_W-1:ADDR_W] = wdata_lo;
      else            ofs_d[ADDR_W-1:0]    = wdata_lo;
      ld_d = ld_q + CNT_W'(1);
    end else if (ser_sh) begin
      ofs_d = {ofs_q[SR_W-2:0], ser_din};
      ld_d  = ld_q + CNT_W'(1);
    end
    wcount  = wbin - rbin_sync;
    full    = (wcount == DEPTH_P);
    free    = DEPTH_P - wcount;
    mem_we  = wrst_n && wen && !full && !loading;
    wbin_d  = wbin + PTR_W'(mem_we);
    wgray_d = wbin_d ^ (wbin_d >> 1);
  end

  // configuration: captured during master reset, kept across partial reset
  always_ff @(posedge wclk) begin
    if (!wmrst_n) begin
      sel_q <= ofs_sel_i;
      ser_q <= ser_mode_i;
      fwft  <= fwft_i;
      ofs_q <= {2{ADDR_W'(preset_ofs(ofs_sel_i))}};
      ld_q  <= '0;
    end else begin
      ofs_q <= ofs_d;
      ld_q  <= ld_d;
    end
  end

  // pointer registers
  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_d;
      wgray <= wgray_d;
    end
  end

  assign waddr   = wbin[ADDR_W-1:0];
  assign ae_ofs  = ofs_q[SR_W-1:ADDR_W];
  assign af_ofs  = ofs_q[ADDR_W-1:0];
  assign wr_flag = fwft ? !full : full;
  assign afull   = (free <= PTR_W'(af_ofs));

  // R1
  no_overflow_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wen && full) |=> $stable(wbin));
  // R4
  wr_count_bound_chk: assert property (@(posedge wclk) disable iff (!wrst_n)
    wcount <= DEPTH_P);
  // R9
  serial_len_chk: assert property (@(posedge wclk) disable iff (!wmrst_n)
    ld_q <= CNT_W'(SR_W));
endmodule

// File: rtl/fifo_rd_side.sv
module fifo_rd_side #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 36
) (
  input  logic              rclk,
  input  logic              rrst_n,
  input  logic              ren,
  input  logic              fwft,
  input  logic [ADDR_W-1:0] ae_ofs,
  input  logic [ADDR_W:0]   wbin_sync,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [ADDR_W:0]   rgray,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_flag,
  output logic              aempty
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(DEPTH);

  logic [PTR_W-1:0]  rbin, rbin_d, rgray_d, mcount, stored;
  logic              valid, valid_d, pop, empty_m;
  logic [DATA_W-1:0] rdata_d;

  // next-state logic
  always_comb begin
    mcount  = wbin_sync - rbin;
    empty_m = (mcount == '0);
    if (fwft) begin
      pop     = !empty_m && (!valid || ren);
      valid_d = !empty_m || (valid && !ren);
    end else begin
      pop     = ren && !empty_m;
      valid_d = 1'b0;
    end
    rdata_d = pop ? mem_rdata : rdata;
    rbin_d  = rbin + PTR_W'(pop);
    rgray_d = rbin_d ^ (rbin_d >> 1);
    stored  = mcount + PTR_W'(valid);
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
      valid <= 1'b0;
      rdata <= '0;
    end else begin
      rbin  <= rbin_d;
      rgray <= rgray_d;
      valid <= valid_d;
      rdata <= rdata_d;
    end
  end

  assign raddr   = rbin[ADDR_W-1:0];
  assign rd_flag = fwft ? valid : empty_m;
  assign aempty  = (stored <= PTR_W'(ae_ofs));

  // R2
  no_underflow_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (!fwft && ren && empty_m) |=> ($stable(rbin) && $stable(rdata)));
  // R3
  or_hold_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    (fwft && valid && !ren) |=> (valid && $stable(rdata)));
  // R5
  rd_count_bound_chk: assert property (@(posedge rclk) disable iff (!rrst_n)
    mcount <= DEPTH_P);
endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
  import fifo_pkg::*;
#(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 7
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              mrst_n,
  input  logic              prst_n,
  input  logic              fwft_sel,
  input  logic [1:0]        ofs_sel,
  input  logic              ser_mode,
  input  logic              wen,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ser_en,
  input  logic              ser_din,
  input  logic              ren,
  output logic [DATA_W-1:0] rdata,
  output logic              wr_flag,
  output logic              almost_full,
  output logic              rd_flag,
  output logic              almost_empty
);
  localparam int PTR_W = ADDR_W + 1;

  logic              ptr_arst_n, wrst_n, wmrst_n, rrst_n;
  logic              mem_we, fwft;
  logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
  logic [PTR_W-1:0]  wgray, rgray, wbin_sync, rbin_sync;
  logic [DATA_W-1:0] mem_rdata;

  assign ptr_arst_n = mrst_n & prst_n;

  fifo_rst_sync u_wptr_rst (.clk(wclk), .arst_n(ptr_arst_n), .srst_n(wrst_n));
  fifo_rst_sync u_wcfg_rst (.clk(wclk), .arst_n(mrst_n),     .srst_n(wmrst_n));
  fifo_rst_sync u_rptr_rst (.clk(rclk), .arst_n(ptr_arst_n), .srst_n(rrst_n));

  fifo_ptr_xing #(.W(PTR_W)) u_w2r (
    .clk(rclk), .rst_n(rrst_n), .gray_in(wgray), .bin_out(wbin_sync));
  fifo_ptr_xing #(.W(PTR_W)) u_r2w (
    .clk(wclk), .rst_n(wrst_n), .gray_in(rgray), .bin_out(rbin_sync));

  fifo_wr_side #(.ADDR_W(ADDR_W)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wmrst_n(wmrst_n), .wen(wen),
    .wdata_lo(wdata[ADDR_W-1:0]), .ofs_sel_i(ofs_sel_e'(ofs_sel)),
    .ser_mode_i(ser_mode), .fwft_i(fwft_sel), .ser_en(ser_en), .ser_din(ser_din),
    .rbin_sync(rbin_sync), .mem_we(mem_we), .waddr(waddr), .wgray(wgray),
    .fwft(fwft), .ae_ofs(ae_ofs), .af_ofs(af_ofs), .wr_flag(wr_flag),
    .afull(almost_full));

  fifo_dpram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .wclk(wclk), .we(mem_we), .waddr(waddr), .wdata(wdata),
    .raddr(raddr), .rdata(mem_rdata));

  fifo_rd_side #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .ren(ren), .fwft(fwft), .ae_ofs(ae_ofs),
    .wbin_sync(wbin_sync), .mem_rdata(mem_rdata), .raddr(raddr), .rgray(rgray),
    .rdata(rdata), .rd_flag(rd_flag), .aempty(almost_empty));
endmodule

// File: tb/tb_dual_clk_fifo.sv
`timescale 1ns/1ps
module tb_dual_clk_fifo;
  localparam int DW    = 36;
  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;
  localparam int SRW   = 2 * AW;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0, ser_mode = 1'b0;
  logic          wen = 1'b0, ser_en = 1'b0, ser_din = 1'b0, ren = 1'b0;
  logic [1:0]    ofs_sel = 2'b00;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          wr_flag, almost_full, rd_flag, almost_empty;

  dual_clk_fifo dut (
    .wclk(clk), .rclk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
    .fwft_sel(fwft_sel), .ofs_sel(ofs_sel), .ser_mode(ser_mode),
    .wen(wen), .wdata(wdata), .ser_en(ser_en), .ser_din(ser_din), .ren(ren),
    .rdata(rdata), .wr_flag(wr_flag), .almost_full(almost_full),
    .rd_flag(rd_flag), .almost_empty(almost_empty));

  int    checks = 0, fails = 0, cyc = 0, edges = 0;
  bit    done = 1'b0;
  string ph = "R7";

  // behavioural reference model state
  int s1 = 0, s2 = 0, c1 = 0, c2 = 0;
  int wcnt = 0, rcnt = 0, ws1 = 0, ws2 = 0, rs1 = 0, rs2 = 0;
  logic [DW-1:0] q[$];
  bit  m_valid = 1'b0, m_fwft = 1'b0, m_ser = 1'b0;
  logic [DW-1:0] m_rdata = '0;
  int  m_sel = 0, m_ae = 8, m_af = 8, m_ld = 0;

  function automatic int preset(int s);
    case (s)
      0: return 8;
      1: return 16;
      2: return 64;
      default: return 0;
    endcase
  endfunction

  task automatic cmp(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", ph, tag, got, exp);
    end
  endtask

  always @(posedge clk) begin : model
    bit prst, crst, full, loading, wacc, pop, nvalid;
    int wc, mc, sr;
    edges++;
    if (!(mrst_n && prst_n)) begin s1 = 0; s2 = 0; end
    if (!mrst_n) begin c1 = 0; c2 = 0; end
    prst    = (s2 == 0);
    crst    = (c2 == 0);
    wc      = wcnt - rs2;
    full    = (wc == DEPTH);
    mc      = ws2 - rcnt;
    loading = (m_sel == 3) && !m_ser && (m_ld < 2);
    wacc    = !prst && wen && !full && !loading;
    if (prst) begin
      wcnt = 0; rcnt = 0; ws1 = 0; ws2 = 0; rs1 = 0; rs2 = 0;
      q.delete(); m_valid = 1'b0; m_rdata = '0;
    end else begin
      pop    = m_fwft ? (mc != 0 && (!m_valid || ren)) : (ren && mc != 0);
      nvalid = m_fwft ? (mc != 0 || (m_valid && !ren)) : 1'b0;
      ws2 = ws1; ws1 = wcnt; rs2 = rs1; rs1 = rcnt;
      if (pop) begin m_rdata = q.pop_front(); rcnt++; end
      m_valid = nvalid;
      if (wacc) begin q.push_back(wdata); wcnt++; end
    end
    if (crst) begin
      m_sel = ofs_sel; m_ser = ser_mode; m_fwft = fwft_sel;
      m_ae = preset(ofs_sel); m_af = m_ae; m_ld = 0;
    end else if (!prst && loading && wen) begin
      if (m_ld == 0) m_ae = int'(wdata[AW-1:0]);
      else           m_af = int'(wdata[AW-1:0]);
      m_ld++;
    end else if (!prst && m_sel == 3 && m_ser && m_ld < SRW && ser_en) begin
      sr   = (m_ae << AW) | m_af;
      sr   = ((sr << 1) | int'(ser_din)) & ((1 << SRW) - 1);
      m_ae = sr >> AW;
      m_af = sr & (DEPTH - 1);
      m_ld++;
    end
    s2 = s1; s1 = (mrst_n && prst_n) ? 1 : 0;
    c2 = c1; c1 = mrst_n ? 1 : 0;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (edges >= 1 && mrst_n && prst_n && !done) begin
      int  wc, mc;
      bit  e_full;
      wc     = wcnt - rs2;
      mc     = ws2 - rcnt;
      e_full = (wc == DEPTH);
      cmp("R4 wr_flag", DW'(wr_flag), DW'(m_fwft ? !e_full : e_full));
      cmp("R6 almost_full", DW'(almost_full), DW'((DEPTH - wc) <= m_af));
      cmp("R5 R11 rd_flag", DW'(rd_flag), DW'(m_fwft ? m_valid : (mc == 0)));
      cmp("R6 almost_empty", DW'(almost_empty), DW'((mc + int'(m_valid)) <= m_ae));
      cmp(m_fwft ? "R3 R1 rdata" : "R2 R1 rdata", rdata, m_rdata);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog R1: got %0d cycles expected under 150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic mreset(int sel, bit fw, bit ser);
    @(negedge clk);
    mrst_n = 1'b0; wen = 1'b0; ren = 1'b0; ser_en = 1'b0;
    ofs_sel = 2'(sel); fwft_sel = fw; ser_mode = ser;
    repeat (4) @(negedge clk);
    mrst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic preset_flush();
    @(negedge clk);
    prst_n = 1'b0; wen = 1'b0; ren = 1'b0;
    repeat (3) @(negedge clk);
    prst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic traffic(int n, int pw, int pr);
    repeat (n) begin
      @(negedge clk);
      wen   = (int'($urandom() % 100) < pw);
      ren   = (int'($urandom() % 100) < pr);
      wdata = DW'({$urandom(), $urandom()});
    end
    @(negedge clk);
    wen = 1'b0; ren = 1'b0;
  endtask

  task automatic dchk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    #2;
    cmp(tag, got, exp);
  endtask

  initial begin
    // Phase A: preset 8, standard mode
    ph = "R7";
    mreset(0, 1'b0, 1'b0);
    ph = "R12";
    dchk("R12 reset empty", DW'(rd_flag), DW'(1));
    dchk("R12 reset not full", DW'(wr_flag), DW'(0));
    dchk("R12 reset rdata", rdata, '0);
    ph = "R11";
    @(negedge clk); wen = 1'b1; wdata = 36'h0_ABCD_1234;
    @(negedge clk); wen = 1'b0;
    dchk("R11 empty after edge k", DW'(rd_flag), DW'(1));
    @(negedge clk); dchk("R11 empty after edge k+1", DW'(rd_flag), DW'(1));
    @(negedge clk); dchk("R11 not empty after edge k+2", DW'(rd_flag), DW'(0));
    ren = 1'b1;
    @(negedge clk); ren = 1'b0;
    dchk("R2 read returns word", rdata, 36'h0_ABCD_1234);
    ph = "R7";
    traffic(300, 100, 0);
    ph = "R1";
    dchk("R1 full after overfill", DW'(wr_flag), DW'(1));
    traffic(300, 0, 100);
    ph = "R7";
    traffic(2000, 60, 55);

    // Phase B: preset 16, fall-through mode
    ph = "R12";
    mreset(1, 1'b1, 1'b0);
    dchk("R12 fwft output not ready", DW'(rd_flag), DW'(0));
    dchk("R12 fwft input ready", DW'(wr_flag), DW'(1));
    ph = "R3";
    @(negedge clk); wen = 1'b1; wdata = 36'h5_0000_0077;
    @(negedge clk); wen = 1'b0;
    repeat (3) @(negedge clk);
    dchk("R3 fall-through word", rdata, 36'h5_0000_0077);
    dchk("R3 output ready", DW'(rd_flag), DW'(1));
    traffic(300, 100, 0);
    traffic(300, 0, 100);
    traffic(2000, 55, 60);

    // Phase C: preset 64, standard mode
    ph = "R7";
    mreset(2, 1'b0, 1'b0);
    traffic(300, 100, 0);
    traffic(1500, 50, 50);
    traffic(300, 0, 100);

    // Phase D: parallel offsets, standard mode, then partial reset
    ph = "R8";
    mreset(3, 1'b0, 1'b0);
    @(negedge clk); wen = 1'b1; wdata = 36'd5;
    @(negedge clk); wdata = 36'd3;
    @(negedge clk); wen = 1'b0;
    repeat (3) @(negedge clk);
    dchk("R8 offset words not stored", DW'(rd_flag), DW'(1));
    traffic(300, 100, 0);
    traffic(1000, 50, 50);
    ph = "R10";
    traffic(40, 100, 0);
    preset_flush();
    dchk("R10 empty after flush", DW'(rd_flag), DW'(1));
    traffic(300, 100, 0);
    traffic(300, 0, 100);
    traffic(1000, 52, 50);

    // Phase E: serial offsets, fall-through mode, then partial reset
    ph = "R9";
    mreset(3, 1'b1, 1'b1);
    begin
      logic [SRW-1:0] pat;
      pat = {7'd10, 7'd20};
      for (int i = SRW - 1; i >= 0; i--) begin
        @(negedge clk); ser_en = 1'b1; ser_din = pat[i];
      end
      for (int i = 0; i < 3; i++) begin
        @(negedge clk); ser_en = 1'b1; ser_din = 1'b1;
      end
      @(negedge clk); ser_en = 1'b0; ser_din = 1'b0;
    end
    traffic(300, 100, 0);
    traffic(300, 0, 100);
    traffic(1000, 50, 50);
    ph = "R10";
    traffic(60, 100, 10);
    preset_flush();
    dchk("R10 fwft not ready after flush", DW'(rd_flag), DW'(0));
    traffic(300, 100, 0);
    traffic(1000, 45, 55);

    repeat (10) @(negedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule